// File: doc/BRIEF.md
# Sector Write-Protect Controller

This block holds the write-protect state of a sixteen-sector parallel NOR flash. Each sector has one protect bit. A set bit drives that sector's line on the `inhibit` bus, and the program/erase engine uses that line to refuse program and erase commands aimed at the sector. The bits change only in a test-programming mode. In that mode a high voltage sits on one address pin and on the output-enable pin. Here that voltage arrives as two digital flags, `hv_a9` and `hv_oe`. Address bits A6, A1 and A0 hold a fixed pattern that picks the operation, and write enable is pulsed low.

A protect pulse sets the bit of the sector named by A18..A15. An unprotect pulse clears every bit at once. It acts only when write enable is held low long enough and only when every sector is already protected. A verify mode reads the state of the addressed sector back as a status byte on `dout`. All control inputs are active low and are sampled on the rising edge of `clk`.

Top module: `sector_guard`

## Requirements
- R1: After synchronous reset (`rst` high), all protect bits are clear (`inhibit` = 0), `dout` = 00h and `dout_en` = 0.
- R2: Protect pulse. A clock edge samples `we_n` going from 1 to 0 while `hv_a9`=1, `hv_oe`=1, `ce_n`=0 and (A6,A1,A0)=(0,1,0). This starts a protect pulse for sector `addr[18:15]`. The first later edge that samples `we_n`=1 sets that sector's bit, provided the flags, `ce_n` and the address are unchanged. The bit is visible from that edge on.
- R3: If `addr` changes, or either high-voltage flag or `ce_n` leaves its required state, before `we_n` returns high, the pulse is abandoned and no protect bit changes.
- R4: Verify. An edge samples `hv_a9`=1, `hv_oe`=0, `oe_n`=0, `we_n`=1, `ce_n`=0 and (A6,A1,A0) equal to (0,1,0) or (1,1,0). After that edge, `dout` = {7'b0, bit of sector `addr[18:15]`} and `dout_en` = 1. So it reads 01h for a protected sector and 00h for an unprotected one. On every other edge, `dout` becomes 00h and `dout_en` 0.
- R5: Unprotect. A falling `we_n` is sampled with the same conditions as R2 but (A6,A1,A0)=(1,1,0). If `we_n` is then sampled low on UNPROT_CYCLES consecutive edges, with all conditions and the address held, and all 16 bits are set, then every bit clears at that edge.
- R6: If `we_n` rises, or a condition or the address changes, before UNPROT_CYCLES low samples, the unprotect is abandoned and the bits are left unchanged.
- R7: An unprotect pulse of full length leaves the bits unchanged when any sector is unprotected.
- R8: `inhibit[i]` equals the protect bit of sector i at all times.
- R9: Write-enable pulses with either high-voltage flag low, or with any other (A6,A1,A0) pattern, change no protect bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 19 | Address; [18:15] sector, [6],[1],[0] mode pattern |
| hv_a9 | input | 1 | High voltage present on address pin 9 |
| hv_oe | input | 1 | High voltage present on output-enable pin |
| dout | output | 8 | Verify status byte |
| dout_en | output | 1 | Status byte valid |
| inhibit | output | 16 | Per-sector program/erase inhibit |

## Verification
A protect bit appears on `inhibit` just after the edge that first samples `we_n` high again. An unprotect clear appears just after the edge that takes the UNPROT_CYCLES-th low sample. A verify byte is registered, so it is due one edge after the verify inputs are applied. The bench drives inputs on the falling clock edge. It advances its reference model on the rising edge and compares every output on the next falling edge, so each result is checked in the exact cycle in which it is due. Directed pulses of length UNPROT_CYCLES-1 and UNPROT_CYCLES probe the timer boundary.

// File: rtl/sg_pkg.sv
package sg_pkg;
    localparam int ADDR_W   = 19;
    localparam int SEC_W    = 4;
    localparam int N_SEC    = 1 << SEC_W;
    localparam int SEC_LSB  = ADDR_W - SEC_W;
    localparam int DATA_W   = 8;
    localparam int PAT_HI   = 6;
    localparam int PAT_MID  = 1;
    localparam int PAT_LO   = 0;

    typedef logic [SEC_W-1:0]  sec_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        PAT_NONE,
        PAT_PROT,
        PAT_UNPROT
    } pat_e;

    typedef struct packed {
        logic hv_ok;
        logic vfy_ok;
        pat_e pat;
        sec_t sector;
    } dec_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PROT,
        SQ_UNPROT,
        SQ_WAIT
    } sq_e;

    function automatic pat_e decode_pat(input addr_t a);
        logic [2:0] p;
        p = {a[PAT_HI], a[PAT_MID], a[PAT_LO]};
        case (p)
            3'b010:  return PAT_PROT;
            3'b110:  return PAT_UNPROT;
            default: return PAT_NONE;
        endcase
    endfunction

    function automatic sec_t sector_of(input addr_t a);
        return a[ADDR_W-1:SEC_LSB];
    endfunction
endpackage

// File: rtl/sg_decode.sv
module sg_decode
    import sg_pkg::*;
(
    input  logic  ce_n,
    input  logic  we_n,
    input  logic  oe_n,
    input  logic  hv_a9,
    input  logic  hv_oe,
    input  addr_t addr,
    output dec_t  dec
);
    always_comb begin
        dec.pat    = decode_pat(addr);
        dec.sector = sector_of(addr);
        // write-side entry: both high-voltage flags, chip selected
        dec.hv_ok  = hv_a9 & hv_oe & ~ce_n;
        // read-side verify: only the address pin at high voltage
        dec.vfy_ok = hv_a9 & ~hv_oe & ~oe_n & we_n & ~ce_n &
                     (dec.pat != PAT_NONE);
    end
endmodule

// File: rtl/sg_seq.sv
module sg_seq
    import sg_pkg::*;
#(
    parameter int UNPROT_CYCLES = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we_n,
    input  addr_t addr,
    input  dec_t  dec,
    input  logic  all_set,
    output logic  set_stb,
    output sec_t  set_sec,
    output logic  clr_stb
);
    localparam int CNT_W = $clog2(UNPROT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UNPROT_CYCLES - 1);

    sq_e              st, st_nx;
    logic             we_q;
    addr_t            lat, lat_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             fall, held;

    assign fall    = we_q & ~we_n;
    assign held    = dec.hv_ok & (addr == lat);
    assign set_sec = sector_of(lat);

    always_comb begin
        st_nx   = st;
        lat_nx  = lat;
        cnt_nx  = cnt;
        set_stb = 1'b0;
        clr_stb = 1'b0;
        case (st)
            SQ_IDLE: begin
                if (fall && dec.hv_ok && dec.pat == PAT_PROT) begin
                    st_nx  = SQ_PROT;
                    lat_nx = addr;
                end else if (fall && dec.hv_ok && dec.pat == PAT_UNPROT) begin
                    st_nx  = SQ_UNPROT;
                    lat_nx = addr;
                    cnt_nx = CNT_W'(1);
                end
            end
            SQ_PROT: begin
                if (!held) begin
                    st_nx = we_n ? SQ_IDLE : SQ_WAIT;
                end else if (we_n) begin
                    set_stb = 1'b1;
                    st_nx   = SQ_IDLE;
                end
            end
            SQ_UNPROT: begin
                if (!held || we_n) begin
                    st_nx = we_n ? SQ_IDLE : SQ_WAIT;
                end else if (cnt == CNT_LAST) begin
                    clr_stb = all_set;
                    st_nx   = SQ_WAIT;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            default: begin
                if (we_n) st_nx = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            we_q <= 1'b1;
            lat  <= '0;
            cnt  <= '0;
        end else begin
            st   <= st_nx;
            we_q <= we_n;
            lat  <= lat_nx;
            cnt  <= cnt_nx;
        end
    end
endmodule

// File: rtl/sg_bits.sv
module sg_bits
    import sg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_stb,
    input  sec_t             set_sec,
    input  logic             clr_stb,
    output logic [N_SEC-1:0] bits,
    output logic             all_set
);
    for (genvar i = 0; i < N_SEC; i++) begin : g_sec
        always_ff @(posedge clk) begin
            if (rst || clr_stb)
                bits[i] <= 1'b0;
            else if (set_stb && set_sec == sec_t'(i))
                bits[i] <= 1'b1;
        end
    end

    assign all_set = &bits;
endmodule

// File: rtl/sg_readout.sv
module sg_readout
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic [N_SEC-1:0]  bits,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    always_ff @(posedge clk) begin
        if (rst || !dec.vfy_ok) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout    <= {{(DATA_W-1){1'b0}}, bits[dec.sector]};
            dout_en <= 1'b1;
        end
    end
endmodule

// File: rtl/sector_guard.sv
module sector_guard
    import sg_pkg::*;
#(
    parameter int UNPROT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hv_a9,
    input  logic              hv_oe,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic [N_SEC-1:0]  inhibit
);
    dec_t dec;
    logic set_stb, clr_stb, all_set;
    sec_t set_sec;

    sg_decode u_dec (
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .hv_a9(hv_a9), .hv_oe(hv_oe), .addr(addr), .dec(dec)
    );

    sg_seq #(.UNPROT_CYCLES(UNPROT_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .we_n(we_n), .addr(addr), .dec(dec),
        .all_set(all_set), .set_stb(set_stb), .set_sec(set_sec),
        .clr_stb(clr_stb)
    );

    sg_bits u_bits (
        .clk(clk), .rst(rst), .set_stb(set_stb), .set_sec(set_sec),
        .clr_stb(clr_stb), .bits(inhibit), .all_set(all_set)
    );

    sg_readout u_rd (
        .clk(clk), .rst(rst), .dec(dec), .bits(inhibit),
        .dout(dout), .dout_en(dout_en)
    );
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk
    import sg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              we_n,
    input logic              hv_a9,
    input logic              hv_oe,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic [N_SEC-1:0]  inhibit
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (inhibit == '0 && dout == '0 && !dout_en));            // R1

    AST_ONE_SET_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $countones(inhibit & ~$past(inhibit)) <= 1);     // R2

    AST_SET_NEEDS_HV_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && |(inhibit & ~$past(inhibit))) |->
        $past(hv_a9 && hv_oe && we_n));                                 // R9

    AST_CLEAR_ONLY_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && |($past(inhibit) & ~inhibit)) |->
        ($past(&inhibit) && inhibit == '0));                            // R7

    AST_CLEAR_WITH_WE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && |($past(inhibit) & ~inhibit)) |->
        $past(!we_n && hv_a9 && hv_oe));                                // R5

    AST_DOUT_SHAPE: assert property (@(posedge clk) disable iff (rst)
        dout_en ? (dout[DATA_W-1:1] == '0) : (dout == '0));            // R4
endmodule

bind sector_guard sector_guard_chk u_chk (
    .clk(clk), .rst(rst), .we_n(we_n), .hv_a9(hv_a9), .hv_oe(hv_oe),
    .dout(dout), .dout_en(dout_en), .inhibit(inhibit)
);

// File: tb/sim_sector_guard.sv
`timescale 1ns/1ps
module sim_sector_guard;
    localparam int LIM = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic        hv_a9 = 1'b0, hv_oe = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic [15:0] inhibit;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sector_guard #(.UNPROT_CYCLES(LIM)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .hv_a9(hv_a9), .hv_oe(hv_oe),
        .dout(dout), .dout_en(dout_en), .inhibit(inhibit)
    );

    // behavioural reference
    bit [15:0]   m_prot;
    bit [7:0]    m_dout;
    bit          m_en;
    bit          m_we_prev;
    int          m_kind;      // 0 none, 1 protect pulse, 2 unprotect pulse, -1 spoiled
    int          m_lows;
    bit [18:0]   m_addr;

    function automatic int pattern(input bit [18:0] a);
        if (a[6] == 0 && a[1] && !a[0]) return 1;
        if (a[6] && a[1] && !a[0]) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_prot = '0; m_dout = '0; m_en = 0;
            m_we_prev = 1; m_kind = 0; m_lows = 0; m_addr = '0;
        end else begin
            bit ok;
            bit [15:0] old;
            old = m_prot;
            ok  = hv_a9 && hv_oe && !ce_n;
            if (hv_a9 && !hv_oe && !oe_n && we_n && !ce_n && pattern(addr) != 0) begin
                m_dout = {7'b0, old[addr[18:15]]};
                m_en   = 1;
            end else begin
                m_dout = '0;
                m_en   = 0;
            end
            if (m_kind == 0) begin
                if (m_we_prev && !we_n && ok && pattern(addr) != 0) begin
                    m_kind = pattern(addr);
                    m_addr = addr;
                    m_lows = 1;
                end
            end else if (m_kind == -1) begin
                if (we_n) m_kind = 0;
            end else if (!ok || addr != m_addr) begin
                m_kind = we_n ? 0 : -1;
            end else if (m_kind == 1) begin
                if (we_n) begin
                    m_prot[m_addr[18:15]] = 1;
                    m_kind = 0;
                end
            end else begin
                if (we_n) m_kind = 0;
                else begin
                    m_lows++;
                    if (m_lows == LIM) begin
                        if (old == 16'hFFFF) m_prot = '0;
                        m_kind = -1;
                    end
                end
            end
            m_we_prev = we_n;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // one clock; compare against the model every cycle
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        if (!rst) begin
            chk("R8 inhibit vs model", inhibit, m_prot);
            chk("R4 dout vs model", {dout_en, dout}, {m_en, m_dout});
        end
    endtask

    function automatic bit [18:0] mk(input int sec, input bit a6, input bit a1, input bit a0);
        return {sec[3:0], 8'b0, a6, 4'b0, a1, a0};
    endfunction

    task automatic idle();
        ce_n = 1; we_n = 1; oe_n = 1; hv_a9 = 0; hv_oe = 0;
    endtask

    // we_n pulse of `lows` cycles with given flags/address
    task automatic pulse(input bit [18:0] a, input int lows, input bit fa9, input bit foe);
        ce_n = 0; oe_n = 1; hv_a9 = fa9; hv_oe = foe; addr = a; we_n = 1;
        cyc();
        we_n = 0;
        for (int i = 0; i < lows; i++) cyc();
        we_n = 1;
        cyc();
        idle();
        cyc();
    endtask

    task automatic rd(input int sec, input bit unp, input int exp, input string tag);
        ce_n = 0; we_n = 1; oe_n = 0; hv_a9 = 1; hv_oe = 0;
        addr = mk(sec, unp, 1, 0);
        cyc();
        chk(tag, {dout_en, dout}, {1'b1, exp[7:0]});
        idle();
        cyc();
    endtask

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        chk("R1 inhibit after reset", inhibit, 0);
        chk("R1 dout after reset", {dout_en, dout}, 0);
        rd(5, 0, 8'h00, "R4 verify unprotected");

        pulse(mk(3, 0, 1, 0), 2, 1, 1);
        chk("R2 protect sector 3", inhibit, 16'h0008);
        rd(3, 0, 8'h01, "R4 verify protected");
        rd(3, 1, 8'h01, "R4 unprotect-verify still protected");
        chk("R8 inhibit bit 3", inhibit[3], 1);

        // address changes mid pulse
        ce_n = 0; hv_a9 = 1; hv_oe = 1; addr = mk(6, 0, 1, 0); cyc();
        we_n = 0; cyc(); addr = mk(7, 0, 1, 0); cyc(); we_n = 1; cyc();
        idle(); cyc();
        chk("R3 address change aborts", inhibit, 16'h0008);

        pulse(mk(9, 0, 1, 0), 2, 1, 0);
        pulse(mk(9, 0, 1, 0), 2, 0, 1);
        pulse(mk(9, 1, 0, 0), 2, 1, 1);
        chk("R9 no effect without both flags/pattern", inhibit, 16'h0008);

        // verify ignored when chip not selected
        ce_n = 1; we_n = 1; oe_n = 0; hv_a9 = 1; hv_oe = 0; addr = mk(3, 0, 1, 0);
        cyc();
        chk("R4 no verify with ce_n high", {dout_en, dout}, 0);
        idle(); cyc();

        pulse(mk(0, 1, 1, 0), LIM + 1, 1, 1);
        chk("R7 unprotect with partial protection", inhibit, 16'h0008);

        for (int s = 0; s < 16; s++) pulse(mk(s, 0, 1, 0), 1 + (s % 3), 1, 1);
        chk("R2 all sectors protected", inhibit, 16'hFFFF);

        pulse(mk(2, 1, 1, 0), LIM - 1, 1, 1);
        chk("R6 short unprotect keeps bits", inhibit, 16'hFFFF);

        // timed clear lands on the LIM-th low sample
        ce_n = 0; hv_a9 = 1; hv_oe = 1; addr = mk(2, 1, 1, 0); we_n = 1; cyc();
        we_n = 0;
        for (int i = 0; i < LIM - 1; i++) cyc();
        chk("R5 not cleared before limit", inhibit, 16'hFFFF);
        cyc();
        chk("R5 cleared at limit", inhibit, 16'h0000);
        we_n = 1; cyc(); idle(); cyc();
        rd(12, 1, 8'h00, "R4 unprotect-verify reads 00h");

        pulse(mk(15, 0, 1, 0), 3, 1, 1);
        chk("R2 protect after unprotect", inhibit, 16'h8000);
        rst = 1; cyc(); rst = 0; cyc();
        chk("R1 reset clears bits", inhibit, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule